// File: doc/BRIEF.md
# Destination-Tag Butterfly Switching Network

This block is an eight-endpoint multistage interconnect made of three columns of identical 2x2 switch elements. A source raises its valid flag and presents a 3-bit destination address and a payload. Each column resolves one address bit, most significant first, so the packet's line index is rewritten from its source number into its destination number one bit per column. Between any source and destination there is exactly one path, so the address bits alone decide the route.

Each column is followed by a register, so a packet injected in cycle c is presented on output port `dest` during cycle c+3, tagged with the index of the source that sent it. Two packets can ask for the same switch output even when their final destinations differ. When that happens, the packet on the upper line of the element (the line whose index has a 0 in the bit being resolved) proceeds, and the other packet is discarded. The source of the discarded packet sees its blocked flag high during the cycle in which the loss occurs. No retry is attempted: the source decides what to do next.

Top module: `butterfly_net`

## Requirements
- R1: A packet from source i with destination d that is not discarded is presented on output port d with `out_valid_o[d]` high, `out_src_o[d]` equal to i and `out_data_o[d]` equal to its payload.
- R2: A packet injected in cycle c is presented on its output port in cycle c+3 only. When no later packets are injected, the output valid flags are low in cycle c+2 and in cycle c+4.
- R3: Column s (s = 0, 1, 2, counted from the inputs) resolves destination bit 2-s. After column s, a packet from source i to destination d sits on the line whose upper s+1 index bits equal the upper s+1 bits of d and whose remaining low bits equal the low bits of i.
- R4: Two surviving packets collide in column s when both would occupy the same line after that column. The packet whose source index has a 0 in bit 2-s wins, and the other is discarded.
- R5: `blocked_o[i]` is high in cycle c+s if and only if the packet injected by source i in cycle c is discarded in column s.
- R6: A discarded packet never appears on any output. Under many-to-one traffic, exactly one packet per destination is delivered and every other packet is blocked.
- R7: An input whose valid flag is low takes no part in routing. Its destination and payload cause no collision, no blocked flag and no output.
- R8: While reset is asserted, and after it is released with no traffic, all output valid flags and all blocked flags are low, even if colliding packets are presented during reset.
- R9: Packets injected in consecutive cycles travel through the columns independently. A collision-free set injected every cycle is delivered every cycle, three cycles later, with no blocked flags raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released inside on the clock |
| in_valid_i | input | 8 | Per-source packet valid flag |
| in_dest_i | input | 8x3 | Per-source destination address |
| in_data_i | input | 8x16 | Per-source payload |
| blocked_o | output | 8 | Per-source flag: this source's packet was discarded this cycle |
| out_valid_o | output | 8 | Per-destination packet valid flag |
| out_src_o | output | 8x3 | Source index of the packet on each output |
| out_data_o | output | 8x16 | Payload of the packet on each output |

## Verification
Three two-packet patterns are chosen so that the only conflict falls in column 0, column 1 or column 2. Each one separates an arbitration or bit-order fault in that column from faults in the others. Identity traffic, a lone packet and random permutations check the line rewriting with no contention, or with the irregular contention that random permutations produce. All-to-one traffic forces losses in every column at once. A pattern that mixes invalid inputs with clashing addresses shows that only valid packets compete. Four XOR permutations injected back to back show that packets in different columns do not interfere, and a collision presented during reset shows that the flags stay quiet until reset is released.

// File: rtl/bf_pkg.sv
package bf_pkg;

  // Line index of the upper input of pair k in a column resolving bit b:
  // the pair number with a zero inserted at position b.
  function automatic int upper_line(input int k, input int b);
    return ((k >> b) << (b + 1)) | (k & ((1 << b) - 1));
  endfunction

  // Lower input of the same pair: the upper line with bit b set.
  function automatic int lower_line(input int k, input int b);
    return upper_line(k, b) + (1 << b);
  endfunction

endpackage

// File: rtl/bf_rst_sync.sv
module bf_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/bf_switch.sv
module bf_switch #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16,
  parameter int BIT    = 0
) (
  input  logic              up_v_i,
  input  logic [ADDR_W-1:0] up_dst_i,
  input  logic [ADDR_W-1:0] up_src_i,
  input  logic [DATA_W-1:0] up_dat_i,
  input  logic              lo_v_i,
  input  logic [ADDR_W-1:0] lo_dst_i,
  input  logic [ADDR_W-1:0] lo_src_i,
  input  logic [DATA_W-1:0] lo_dat_i,
  output logic              o0_v_o,
  output logic [ADDR_W-1:0] o0_dst_o,
  output logic [ADDR_W-1:0] o0_src_o,
  output logic [DATA_W-1:0] o0_dat_o,
  output logic              o1_v_o,
  output logic [ADDR_W-1:0] o1_dst_o,
  output logic [ADDR_W-1:0] o1_src_o,
  output logic [DATA_W-1:0] o1_dat_o,
  output logic              clash_o
);

  logic want_up, want_lo;
  logic o0_from_up, o0_from_lo, o1_from_up, o1_from_lo;

  // Request decode and fixed priority: the upper input claims first.
  always_comb begin
    want_up    = up_dst_i[BIT];
    want_lo    = lo_dst_i[BIT];
    o0_from_up = up_v_i & ~want_up;
    o1_from_up = up_v_i &  want_up;
    o0_from_lo = lo_v_i & ~want_lo & ~o0_from_up;
    o1_from_lo = lo_v_i &  want_lo & ~o1_from_up;
    clash_o    = lo_v_i & ~(o0_from_lo | o1_from_lo);
  end

  // Output steering.
  always_comb begin
    o0_v_o   = o0_from_up | o0_from_lo;
    o0_dst_o = o0_from_lo ? lo_dst_i : up_dst_i;
    o0_src_o = o0_from_lo ? lo_src_i : up_src_i;
    o0_dat_o = o0_from_lo ? lo_dat_i : up_dat_i;
    o1_v_o   = o1_from_up | o1_from_lo;
    o1_dst_o = o1_from_lo ? lo_dst_i : up_dst_i;
    o1_src_o = o1_from_lo ? lo_src_i : up_src_i;
    o1_dat_o = o1_from_lo ? lo_dat_i : up_dat_i;
  end

endmodule

// File: rtl/bf_stage.sv
module bf_stage #(
  parameter int NUM_PORTS = 8,
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 16,
  parameter int STG       = 0
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_PORTS-1:0]              v_i,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  dst_i,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  src_i,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]  dat_i,
  output logic [NUM_PORTS-1:0]              v_o,
  output logic [NUM_PORTS-1:0][ADDR_W-1:0]  dst_o,
  output logic [NUM_PORTS-1:0][ADDR_W-1:0]  src_o,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]  dat_o,
  output logic [NUM_PORTS-1:0]              drop_src_o
);

  localparam int BIT   = ADDR_W - 1 - STG;
  localparam int PAIRS = NUM_PORTS / 2;

  logic              nxt_v   [NUM_PORTS];
  logic [ADDR_W-1:0] nxt_dst [NUM_PORTS];
  logic [ADDR_W-1:0] nxt_src [NUM_PORTS];
  logic [DATA_W-1:0] nxt_dat [NUM_PORTS];
  logic              drop_pair [PAIRS];
  logic [PAIRS-1:0]  drop_vec;

  // Column of switch elements, one per line pair differing in bit BIT.
  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    localparam int U = bf_pkg::upper_line(k, BIT);
    localparam int L = bf_pkg::lower_line(k, BIT);

    bf_switch #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .BIT    (BIT)
    ) u_switch (
      .up_v_i   (v_i[U]),
      .up_dst_i (dst_i[U]),
      .up_src_i (src_i[U]),
      .up_dat_i (dat_i[U]),
      .lo_v_i   (v_i[L]),
      .lo_dst_i (dst_i[L]),
      .lo_src_i (src_i[L]),
      .lo_dat_i (dat_i[L]),
      .o0_v_o   (nxt_v[U]),
      .o0_dst_o (nxt_dst[U]),
      .o0_src_o (nxt_src[U]),
      .o0_dat_o (nxt_dat[U]),
      .o1_v_o   (nxt_v[L]),
      .o1_dst_o (nxt_dst[L]),
      .o1_src_o (nxt_src[L]),
      .o1_dat_o (nxt_dat[L]),
      .clash_o  (drop_pair[k])
    );

    // R4
    upper_keeps_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (v_i[U] && !dst_i[U][BIT]) |=> (v_o[U] && src_o[U] == $past(src_i[U])));
    // R4
    upper_keeps_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (v_i[U] && dst_i[U][BIT]) |=> (v_o[L] && src_o[L] == $past(src_i[U])));
  end

  // Map each lost packet back to the source it came from.
  always_comb begin
    drop_src_o = '0;
    drop_vec   = '0;
    for (int k = 0; k < PAIRS; k++) begin
      drop_vec[k] = drop_pair[k];
      if (drop_pair[k]) begin
        drop_src_o[src_i[bf_pkg::lower_line(k, BIT)]] = 1'b1;
      end
    end
  end

  // Column register; payload fields load only when a packet is present.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o   <= '0;
      dst_o <= '0;
      src_o <= '0;
      dat_o <= '0;
    end else begin
      for (int i = 0; i < NUM_PORTS; i++) begin
        v_o[i] <= nxt_v[i];
        if (nxt_v[i]) begin
          dst_o[i] <= nxt_dst[i];
          src_o[i] <= nxt_src[i];
          dat_o[i] <= nxt_dat[i];
        end
      end
    end
  end

  // R3
  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_line
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
    // R3
    line_high_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      v_o[i] |-> (dst_o[i][ADDR_W-1:BIT] == IDX[ADDR_W-1:BIT]));
    if (BIT > 0) begin : g_low
      // R3
      line_low_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        v_o[i] |-> (src_o[i][BIT-1:0] == IDX[BIT-1:0]));
    end
  end

  // R6
  packet_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ($countones(v_o) ==
      $past($countones(v_i)) - $past($countones(drop_vec))));

endmodule

// File: rtl/butterfly_net.sv
module butterfly_net #(
  parameter  int NUM_PORTS = 8,
  parameter  int DATA_W    = 16,
  localparam int ADDR_W    = $clog2(NUM_PORTS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_PORTS-1:0]             in_valid_i,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0] in_dest_i,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0] in_data_i,
  output logic [NUM_PORTS-1:0]             blocked_o,
  output logic [NUM_PORTS-1:0]             out_valid_o,
  output logic [NUM_PORTS-1:0][ADDR_W-1:0] out_src_o,
  output logic [NUM_PORTS-1:0][DATA_W-1:0] out_data_o
);

  localparam int STAGES = ADDR_W;

  logic rst_n;

  logic [NUM_PORTS-1:0]             lane_v   [STAGES+1];
  logic [NUM_PORTS-1:0][ADDR_W-1:0] lane_dst [STAGES+1];
  logic [NUM_PORTS-1:0][ADDR_W-1:0] lane_src [STAGES+1];
  logic [NUM_PORTS-1:0][DATA_W-1:0] lane_dat [STAGES+1];
  logic [NUM_PORTS-1:0]             lane_drop [STAGES];
  logic [NUM_PORTS-1:0][ADDR_W-1:0] src_tag;
  logic [NUM_PORTS-1:0]             blk_any;

  bf_rst_sync u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  // Each packet enters tagged with the number of its source.
  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      src_tag[p] = ADDR_W'(p);
    end
  end

  assign lane_v[0]   = in_valid_i;
  assign lane_dst[0] = in_dest_i;
  assign lane_src[0] = src_tag;
  assign lane_dat[0] = in_data_i;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    bf_stage #(
      .NUM_PORTS (NUM_PORTS),
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .STG       (s)
    ) u_stage (
      .clk_i      (clk_i),
      .rst_ni     (rst_n),
      .v_i        (lane_v[s]),
      .dst_i      (lane_dst[s]),
      .src_i      (lane_src[s]),
      .dat_i      (lane_dat[s]),
      .v_o        (lane_v[s+1]),
      .dst_o      (lane_dst[s+1]),
      .src_o      (lane_src[s+1]),
      .dat_o      (lane_dat[s+1]),
      .drop_src_o (lane_drop[s])
    );
  end

  // Blocked flags gathered from all columns, quiet while in reset.
  always_comb begin
    blk_any = '0;
    for (int s = 0; s < STAGES; s++) begin
      blk_any = blk_any | lane_drop[s];
    end
    blocked_o = rst_n ? blk_any : '0;
  end

  assign out_valid_o = lane_v[STAGES];
  assign out_src_o   = lane_src[STAGES];
  assign out_data_o  = lane_dat[STAGES];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_chk
    // R1
    port_matches_dest_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
      lane_v[STAGES][p] |-> (lane_dst[STAGES][p] == ADDR_W'(p)));
  end

  // R8
  always_comb begin
    if (!rst_n) begin
      // R8
      quiet_in_reset_chk: assert (blocked_o == '0);
    end
  end

endmodule

// File: tb/test_butterfly_net.sv
`timescale 1ns/1ps
module test_butterfly_net;

  logic                 clk;
  logic                 rst_n;
  logic [7:0]           in_valid;
  logic [7:0][2:0]      in_dest;
  logic [7:0][15:0]     in_data;
  logic [7:0]           blocked;
  logic [7:0]           out_valid;
  logic [7:0][2:0]      out_src;
  logic [7:0][15:0]     out_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [7:0]  m_blk [3];
  logic [7:0]  m_ov;
  logic [2:0]  m_os [8];
  logic [15:0] m_od [8];

  butterfly_net #(.NUM_PORTS(8), .DATA_W(16)) i_butterfly_net (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .in_dest_i   (in_dest),
    .in_data_i   (in_data),
    .blocked_o   (blocked),
    .out_valid_o (out_valid),
    .out_src_o   (out_src),
    .out_data_o  (out_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference collision model built from the line rule and priority rule.
  task automatic model();
    logic [7:0] alive;
    int pos [8];
    alive = in_valid;
    for (int s = 0; s < 3; s++) begin
      int b;
      b = 2 - s;
      m_blk[s] = '0;
      for (int i = 0; i < 8; i++) begin
        pos[i] = ((int'(in_dest[i]) >> b) << b) | (i & ((1 << b) - 1));
      end
      for (int i = 0; i < 8; i++) begin
        for (int j = i + 1; j < 8; j++) begin
          if (alive[i] && alive[j] && pos[i] == pos[j]) begin
            if (((i >> b) & 1) == 1) m_blk[s][i] = 1'b1;
            else                     m_blk[s][j] = 1'b1;
          end
        end
      end
      alive = alive & ~m_blk[s];
    end
    m_ov = '0;
    for (int p = 0; p < 8; p++) begin
      m_os[p] = '0;
      m_od[p] = '0;
    end
    for (int i = 0; i < 8; i++) begin
      if (alive[i]) begin
        m_ov[in_dest[i]] = 1'b1;
        m_os[in_dest[i]] = 3'(i);
        m_od[in_dest[i]] = in_data[i];
      end
    end
  endtask

  // Inject one set of packets, then follow it through every column.
  task automatic run_wave(input logic [7:0] v, input logic [7:0][2:0] d, input string req);
    @(negedge clk);
    in_valid = v;
    in_dest  = d;
    for (int i = 0; i < 8; i++) in_data[i] = 16'($urandom);
    model();
    #1;
    check(blocked == m_blk[0], "R5", {req, " blocked col0"}, 64'(blocked), 64'(m_blk[0]));
    @(negedge clk);
    in_valid = '0;
    in_dest  = '0;
    in_data  = '0;
    #1;
    check(blocked == m_blk[1], "R5", {req, " blocked col1"}, 64'(blocked), 64'(m_blk[1]));
    @(negedge clk);
    #1;
    check(blocked == m_blk[2], "R5", {req, " blocked col2"}, 64'(blocked), 64'(m_blk[2]));
    check(out_valid == 8'h00, "R2", {req, " early output"}, 64'(out_valid), 64'h0);
    @(negedge clk);
    #1;
    check(out_valid == m_ov, req, "out valid", 64'(out_valid), 64'(m_ov));
    check(out_valid == m_ov, "R6", "only survivors delivered", 64'(out_valid), 64'(m_ov));
    for (int p = 0; p < 8; p++) begin
      if (m_ov[p]) begin
        check(out_src[p] == m_os[p], "R1", $sformatf("%s src port %0d", req, p),
              64'(out_src[p]), 64'(m_os[p]));
        check(out_data[p] == m_od[p], "R1", $sformatf("%s data port %0d", req, p),
              64'(out_data[p]), 64'(m_od[p]));
      end
    end
    @(negedge clk);
    #1;
    check(out_valid == 8'h00, "R2", {req, " late output"}, 64'(out_valid), 64'h0);
  endtask

  task automatic t_reset();
    logic [7:0][2:0] d;
    d = '0;
    d[4] = 3'd1;
    repeat (2) @(negedge clk);
    in_valid = 8'h11;
    in_dest  = d;
    #1;
    check(blocked == 8'h00, "R8", "blocked in reset", 64'(blocked), 64'h0);
    check(out_valid == 8'h00, "R8", "valid in reset", 64'(out_valid), 64'h0);
    repeat (4) @(negedge clk);
    #1;
    check(out_valid == 8'h00, "R8", "valid held in reset", 64'(out_valid), 64'h0);
    in_valid = '0;
    in_dest  = '0;
    rst_n    = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(out_valid == 8'h00, "R8", "valid after release", 64'(out_valid), 64'h0);
    check(blocked == 8'h00, "R8", "blocked after release", 64'(blocked), 64'h0);
  endtask

  task automatic t_identity();
    logic [7:0][2:0] d;
    for (int i = 0; i < 8; i++) d[i] = 3'(i);
    run_wave(8'hFF, d, "R1");
  endtask

  task automatic t_single();
    logic [7:0][2:0] d;
    d = '0;
    d[5] = 3'd2;
    run_wave(8'h20, d, "R1");
  endtask

  // Sources 0 and 4 both need the low half in column 0.
  task automatic t_clash_col0();
    logic [7:0][2:0] d;
    d = '0;
    d[4] = 3'd1;
    run_wave(8'h11, d, "R4");
  endtask

  // Sources 0 and 2 meet on line 0 after column 1.
  task automatic t_clash_col1();
    logic [7:0][2:0] d;
    d = '0;
    d[2] = 3'd1;
    run_wave(8'h05, d, "R4");
  endtask

  // Sources 0 and 1 meet only in the last column.
  task automatic t_clash_col2();
    logic [7:0][2:0] d;
    d = '0;
    run_wave(8'h03, d, "R4");
  endtask

  task automatic t_hotspot();
    logic [7:0][2:0] d;
    d = '0;
    run_wave(8'hFF, d, "R6");
    for (int i = 0; i < 8; i++) d[i] = 3'd6;
    run_wave(8'hFF, d, "R6");
  endtask

  // Invalid sources carry clashing addresses and must be ignored.
  task automatic t_invalid();
    logic [7:0][2:0] d;
    d = '0;
    run_wave(8'h01, d, "R7");
    for (int i = 0; i < 8; i++) d[i] = 3'd3;
    run_wave(8'h00, d, "R7");
  endtask

  task automatic t_random();
    int perm [8];
    logic [7:0][2:0] d;
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < 8; i++) perm[i] = i;
      for (int i = 7; i > 0; i--) begin
        int j, t;
        j = int'($urandom_range(i, 0));
        t = perm[i];
        perm[i] = perm[j];
        perm[j] = t;
      end
      for (int i = 0; i < 8; i++) d[i] = 3'(perm[i]);
      run_wave(8'hFF, d, "R3");
    end
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 8; i++) d[i] = 3'($urandom);
      run_wave(8'($urandom), d, "R4");
    end
  endtask

  // Collision-free XOR permutations, one per cycle.
  task automatic t_pipeline();
    int key [4];
    key[0] = 0; key[1] = 7; key[2] = 3; key[3] = 5;
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      if (k < 4) begin
        in_valid = 8'hFF;
        for (int i = 0; i < 8; i++) begin
          in_dest[i] = 3'(i ^ key[k]);
          in_data[i] = 16'(k * 256 + i);
        end
      end else begin
        in_valid = '0;
        in_dest  = '0;
        in_data  = '0;
      end
      #1;
      check(blocked == 8'h00, "R9", $sformatf("blocked step %0d", k), 64'(blocked), 64'h0);
      if (k >= 3) begin
        int w;
        w = k - 3;
        check(out_valid == 8'hFF, "R9", $sformatf("valid wave %0d", w), 64'(out_valid), 64'hFF);
        for (int p = 0; p < 8; p++) begin
          logic [2:0]  es;
          logic [15:0] ed;
          es = 3'(p ^ key[w]);
          ed = 16'(w * 256 + (p ^ key[w]));
          check(out_src[p] == es && out_data[p] == ed, "R9",
                $sformatf("wave %0d port %0d", w, p),
                {45'h0, out_src[p], out_data[p]}, {45'h0, es, ed});
        end
      end
    end
    @(negedge clk);
    #1;
    check(out_valid == 8'h00, "R9", "drained", 64'(out_valid), 64'h0);
  endtask

  initial begin
    rst_n    = 1'b0;
    in_valid = '0;
    in_dest  = '0;
    in_data  = '0;
    void'($urandom(32'h5EED));
    t_reset();
    t_identity();
    t_single();
    t_clash_col0();
    t_clash_col1();
    t_clash_col2();
    t_hotspot();
    t_invalid();
    t_random();
    t_pipeline();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog all requirements: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule